// File: doc/BRIEF.md
# APM Command and Status Mailbox

This block holds two byte-wide scratch registers on a simple I/O bus. Power-management software and a system-management handler use them to exchange a command byte and a status byte. The stored bytes have no effect on the block itself. Accesses to the command register have side effects.

A write to the command register raises a one-cycle system-management interrupt request, but only when both the global SMI enable and the APM write SMI enable are high. A read of the command register pulls an active-low clock-stop output low, but only when a separate stop-clock enable is high. The output stays low until a release pulse arrives. The status register is a plain mailbox with no side effects. Every other address is ignored.

Top module: `apm_mailbox`

## Requirements
- R1: After reset both registers hold 0x00, smi_req is 0 and stpclk_n is 1.
- R2: A write (io_wr=1) to address 0xB2 or 0xB3 stores io_wdata at the clock edge. While io_rd=1 with that address, io_rdata shows the last byte stored there in the same cycle. io_rdata is 0x00 when io_rd=0.
- R3: smi_req is 1 for exactly the one cycle after the edge that accepts a write to 0xB2 with smi_glb_en=1 and smi_apm_wr_en=1. Any other enable combination gives no request.
- R4: A read of 0xB2 with stpclk_rd_en=1 drives stpclk_n to 0 from the next clock edge. With stpclk_rd_en=0 the read leaves stpclk_n at 1.
- R5: A read of 0xB2 never produces smi_req, whatever the enables.
- R6: Reads and writes of 0xB3 change neither smi_req nor stpclk_n.
- R7: Once stpclk_n is 0, it stays 0 through further reads and idle cycles. A one-cycle pulse on stpclk_release returns it to 1 at the next edge. A release wins over a qualifying read in the same cycle.
- R8: Accesses to any address other than 0xB2 and 0xB3, compared over the full address width, store nothing and raise no side effect. Reads at those addresses return 0x00.
- R9: The byte values held in the registers have no effect on smi_req or stpclk_n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | ADDR_W | I/O address |
| io_wdata | input | 8 | Write data |
| io_wr | input | 1 | Write strobe, one access per cycle |
| io_rd | input | 1 | Read strobe |
| io_rdata | output | 8 | Read data, combinational |
| smi_glb_en | input | 1 | Global SMI enable |
| smi_apm_wr_en | input | 1 | APM command-write SMI enable |
| stpclk_rd_en | input | 1 | Enables clock stop on a command read |
| stpclk_release | input | 1 | Pulse that releases the clock-stop output |
| smi_req | output | 1 | One-cycle SMI request |
| stpclk_n | output | 1 | Active-low clock-stop output |

## Verification
Read data is combinational, so the bench samples io_rdata a quarter period after it drives the strobe, in the same cycle. smi_req and stpclk_n each pass through one register. They are sampled one time unit after the edge that accepts the access, and smi_req is sampled again a cycle later to confirm that the pulse has ended. Inputs change on the falling edge. The bench sweeps all four SMI enable combinations against several data bytes, and sweeps every address from 0x00 to 0xFF plus aliases above 0xFF.

// File: rtl/apm_mailbox.sv
module apm_mailbox #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] CMD_ADDR = 'hB2,
  parameter logic [ADDR_W-1:0] STS_ADDR = 'hB3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic [7:0]        io_wdata,
  input  logic              io_wr,
  input  logic              io_rd,
  output logic [7:0]        io_rdata,
  input  logic              smi_glb_en,
  input  logic              smi_apm_wr_en,
  input  logic              stpclk_rd_en,
  input  logic              stpclk_release,
  output logic              smi_req,
  output logic              stpclk_n
);

  logic [7:0] cmd_q, sts_q;
  logic       smi_q, stop_q;

  wire hit_cmd = (io_addr == CMD_ADDR);
  wire hit_sts = (io_addr == STS_ADDR);
  wire cmd_wr  = io_wr & hit_cmd;
  wire sts_wr  = io_wr & hit_sts;
  wire cmd_rd  = io_rd & hit_cmd;
  wire sts_rd  = io_rd & hit_sts;

  wire smi_fire  = cmd_wr & smi_glb_en & smi_apm_wr_en;
  wire stop_fire = cmd_rd & stpclk_rd_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= '0;
      sts_q <= '0;
    end else begin
      if (cmd_wr) cmd_q <= io_wdata;
      if (sts_wr) sts_q <= io_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smi_q  <= 1'b0;
      stop_q <= 1'b0;
    end else begin
      smi_q <= smi_fire;
      if (stpclk_release)  stop_q <= 1'b0;
      else if (stop_fire)  stop_q <= 1'b1;
    end
  end

  assign io_rdata = cmd_rd ? cmd_q : (sts_rd ? sts_q : 8'h00);
  assign smi_req  = smi_q;
  assign stpclk_n = ~stop_q;

  // R3: a request only follows an enabled command write
  p_smi_source_r3: assert property (@(posedge clk) disable iff (!rst_n)
    smi_req |-> $past(io_wr && hit_cmd && smi_glb_en && smi_apm_wr_en));

  // R5: a pure read cycle never yields a request
  p_no_smi_on_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!io_wr) |-> !smi_req);

  // R4: a falling clock-stop needs an enabled command read
  p_stop_source_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stpclk_n) |-> $past(io_rd && hit_cmd && stpclk_rd_en));

  // R7: held low until release
  p_stop_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!stpclk_n && !stpclk_release) |=> !stpclk_n);

  // R7: release wins
  p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stpclk_release |=> stpclk_n);

  // R8: unmapped reads return zero
  p_unmapped_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(hit_cmd || hit_sts) |-> (io_rdata == 8'h00));

  // R6: status register only moves on its own write
  p_sts_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!(io_wr && hit_sts)) |-> $stable(sts_q));

endmodule

// File: tb/apm_mailbox_tb.sv
module apm_mailbox_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] io_addr = '0;
  logic [7:0]  io_wdata = '0;
  logic        io_wr = 1'b0, io_rd = 1'b0;
  logic [7:0]  io_rdata;
  logic        smi_glb_en = 1'b0, smi_apm_wr_en = 1'b0, stpclk_rd_en = 1'b0;
  logic        stpclk_release = 1'b0;
  logic        smi_req, stpclk_n;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [7:0] rd_seen;

  always #(CLK_PERIOD/2) clk = ~clk;

  apm_mailbox u_dut (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wdata(io_wdata),
    .io_wr(io_wr), .io_rd(io_rd), .io_rdata(io_rdata),
    .smi_glb_en(smi_glb_en), .smi_apm_wr_en(smi_apm_wr_en),
    .stpclk_rd_en(stpclk_rd_en), .stpclk_release(stpclk_release),
    .smi_req(smi_req), .stpclk_n(stpclk_n)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // called just after a falling edge; drives one access, returns sampled read data
  task automatic cyc(input logic [15:0] a, input logic [7:0] d,
                     input logic w, input logic r, input logic rel);
    io_addr = a; io_wdata = d; io_wr = w; io_rd = r; stpclk_release = rel;
    #(CLK_PERIOD/4);
    rd_seen = io_rdata;
    @(posedge clk); #1;
    io_wr = 0; io_rd = 0; stpclk_release = 0;
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD*200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    logic [7:0] vals [4];
    vals[0] = 8'h00; vals[1] = 8'h5A; vals[2] = 8'hFF; vals[3] = 8'h81;
    #(CLK_PERIOD*3);
    @(negedge clk); rst_n = 1;
    @(negedge clk);

    // R1 reset state
    chk("R1 smi_req", {7'b0, smi_req}, 8'h00);
    chk("R1 stpclk_n", {7'b0, stpclk_n}, 8'h01);
    cyc(16'hB2, 0, 0, 1, 0); chk("R1 cmd reset", rd_seen, 8'h00);
    @(negedge clk);
    cyc(16'hB3, 0, 0, 1, 0); chk("R1 sts reset", rd_seen, 8'h00);
    @(negedge clk);

    // R3/R5/R9/R2 enable x data sweep
    for (int en = 0; en < 4; en++) begin
      for (int k = 0; k < 4; k++) begin
        smi_glb_en = en[1]; smi_apm_wr_en = en[0];
        cyc(16'hB2, vals[k], 1, 0, 0);
        chk("R3 smi pulse", {7'b0, smi_req}, (en == 3) ? 8'h01 : 8'h00);
        @(negedge clk);
        cyc(16'h0000, 0, 0, 0, 0);
        chk("R3 single cycle", {7'b0, smi_req}, 8'h00);
        @(negedge clk);
        smi_glb_en = 1; smi_apm_wr_en = 1;
        cyc(16'hB2, 0, 0, 1, 0);
        chk("R2 cmd readback", rd_seen, vals[k]);
        chk("R5 no smi on read", {7'b0, smi_req}, 8'h00);
        chk("R9 stpclk unaffected", {7'b0, stpclk_n}, 8'h01);
        @(negedge clk);
      end
    end
    chk("R2 rdata idle", io_rdata, 8'h00);

    // R4 / R7 clock stop
    stpclk_rd_en = 0;
    cyc(16'hB2, 0, 0, 1, 0);
    chk("R4 disabled read", {7'b0, stpclk_n}, 8'h01);
    @(negedge clk);
    stpclk_rd_en = 1;
    cyc(16'hB2, 0, 0, 1, 0);
    chk("R4 enabled read", {7'b0, stpclk_n}, 8'h00);
    @(negedge clk);
    cyc(16'hB2, 0, 0, 1, 0);
    chk("R7 repeat read", {7'b0, stpclk_n}, 8'h00);
    @(negedge clk);
    for (int i = 0; i < 5; i++) begin
      cyc(16'h0000, 0, 0, 0, 0);
      chk("R7 hold low", {7'b0, stpclk_n}, 8'h00);
      @(negedge clk);
    end
    cyc(16'h0000, 0, 0, 0, 1);
    chk("R7 release", {7'b0, stpclk_n}, 8'h01);
    @(negedge clk);
    cyc(16'hB2, 0, 0, 1, 1);
    chk("R7 release wins", {7'b0, stpclk_n}, 8'h01);
    @(negedge clk);
    cyc(16'hB2, 0, 0, 1, 0);
    chk("R4 stop again", {7'b0, stpclk_n}, 8'h00);
    @(negedge clk);
    cyc(16'h0000, 0, 0, 0, 1);
    chk("R7 release again", {7'b0, stpclk_n}, 8'h01);
    @(negedge clk);

    // R6 status register, all enables on
    for (int k = 0; k < 4; k++) begin
      cyc(16'hB3, vals[k] ^ 8'h3C, 1, 0, 0);
      chk("R6 sts write no smi", {7'b0, smi_req}, 8'h00);
      @(negedge clk);
      cyc(16'hB3, 0, 0, 1, 0);
      chk("R6 sts readback", rd_seen, vals[k] ^ 8'h3C);
      chk("R6 sts read no stop", {7'b0, stpclk_n}, 8'h01);
      @(negedge clk);
    end
    cyc(16'hB2, 0, 0, 1, 1);
    chk("R6 cmd untouched", rd_seen, vals[3]);
    @(negedge clk);

    // R8 address sweep
    for (int a = 0; a < 264; a++) begin
      logic [15:0] ad;
      ad = (a < 256) ? 16'(a) : 16'(16'h0100 * (a - 255) + 16'hB2);
      if (ad == 16'hB2 || ad == 16'hB3) continue;
      cyc(ad, 8'hC3, 1, 0, 0);
      chk("R8 unmapped write no smi", {7'b0, smi_req}, 8'h00);
      @(negedge clk);
      cyc(ad, 0, 0, 1, 0);
      chk("R8 unmapped read zero", rd_seen, 8'h00);
      chk("R8 unmapped read no stop", {7'b0, stpclk_n}, 8'h01);
      @(negedge clk);
    end
    cyc(16'hB2, 0, 0, 1, 1);
    chk("R8 cmd kept", rd_seen, vals[3]);
    @(negedge clk);
    cyc(16'hB3, 0, 0, 1, 0);
    chk("R8 sts kept", rd_seen, vals[3] ^ 8'h3C);
    @(negedge clk);

    finish_up();
  end
endmodule